// File: doc/BRIEF.md
# Program Counter and Interrupt Sequencer

This block steps the program counter of a small processor core in which every instruction lasts exactly two clock cycles. It holds a 10-bit program address and picks the next one at the end of each instruction's second cycle. The next address comes from one of these sources: the next sequential address, an absolute target (jump or call, optionally gated by a flag test), the value popped from a return-address stack (subroutine return or interrupt return), or the fixed interrupt vector. It also owns the zero and carry flags, their shadow copies, and the interrupt-enable flag.

The instruction decoder supplies the operation code, condition selector, target address and the flag update from the ALU directly. An external return-address stack is driven through push and pop strobes. The block presents the stack's top entry on an input and receives a clear request during reset.

An interrupt request is taken only at an instruction boundary. It replaces the instruction that would have started with a two-cycle event. That event saves the preempted address, copies the flags into shadow storage, disables further interrupts, loads the vector and raises an acknowledge in its second cycle. The interrupt return restores the flags and resumes at the saved address, so the preempted instruction then runs.

Top module: `pgm_seq`

## Requirements
- R1: `secondCycle` is 0 in the first cycle after reset and alternates every clock; `pc` changes only at the clock edge that ends a second cycle.
- R2: A plain instruction (opCode 0, or the unused code 7) advances `pc` by one, wrapping from 3FF to 000.
- R3: JUMP (opCode 1) and CALL (opCode 2) load `target` when the condition holds. When it fails they advance by one. The condition is encoded as follows: condSel[2]=0 means always; otherwise condSel[1:0] = 00 zero set, 01 zero clear, 10 carry set, 11 carry clear.
- R4: A taken CALL raises `pushEn` in its second cycle with `pushAddr` equal to its own address. RETURN (opCode 3, same condition field) raises `popEn` when taken and loads `stackTop`+1, wrapping 3FF to 000; an untaken RETURN pops nothing and advances by one.
- R5: With `flagWe` high in an instruction's second cycle, `zeroFlag` and `carryFlag` take `zeroIn` and `carryIn` at the end of that instruction; otherwise they hold.
- R6: `irq` is sampled at every clock edge. A sample taken at the end of a first cycle causes an interrupt after the current instruction only if interrupts are enabled at its end. With interrupts disabled the request has no effect. A request held high for two clocks is always seen.
- R7: The interrupt event lasts two cycles instead of the next instruction. Its behaviour is as follows:
  - `intAck` is high only in the event's second cycle.
  - `pushEn` pushes the preempted address.
  - `pc` becomes 3FF.
  - `intEnabled` clears.
  - The flags are copied to shadow storage and themselves stay unchanged.
  - Decoder inputs during the event are ignored.
- R8: RETURNI (opCode 4) always pops. It loads `stackTop` without adding one and restores both flags from the shadow copies. It sets `intEnabled` to `retiEn`.
- R9: opCode 5 sets and opCode 6 clears `intEnabled`, each advancing `pc` by one.
- R10: While `rst` is high: `pc`=0, both flags 0, `intEnabled`=0, `intAck`=0, `stackClear`=1. Reset wins over a pending interrupt.
- R11: `pushEn` and `popEn` are never high together and only in a second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opCode | input | 3 | Decoded operation, valid in the second cycle |
| condSel | input | 3 | Condition selector for jump, call, return |
| target | input | 10 | Absolute jump or call address |
| retiEn | input | 1 | Interrupt-enable value applied by RETURNI |
| flagWe | input | 1 | ALU flag update strobe |
| zeroIn | input | 1 | New zero flag from ALU |
| carryIn | input | 1 | New carry flag from ALU |
| irq | input | 1 | Interrupt request |
| stackTop | input | 10 | Top entry of the return-address stack |
| pc | output | 10 | Current program address |
| secondCycle | output | 1 | High in the second cycle of an instruction or event |
| intAck | output | 1 | Interrupt acknowledge |
| pushEn | output | 1 | Push strobe to the stack |
| popEn | output | 1 | Pop strobe to the stack |
| pushAddr | output | 10 | Address to push |
| stackClear | output | 1 | Stack clear request |
| zeroFlag | output | 1 | Zero flag |
| carryFlag | output | 1 | Carry flag |
| intEnabled | output | 1 | Interrupt-enable flag |

## Verification
The assertions check the following on every cycle:
- the alternation of the two cycles and the hold of the address in the first cycle;
- sequential advance and return-plus-one arithmetic;
- the single-cycle acknowledge followed by the vector load and the enable clear;
- the exclusivity and placement of the stack strobes;
- the reset values.

The bench scenarios show what needs a whole history to judge:
- the condition codes taken and not taken;
- interrupts ignored while disabled;
- the exact boundary at which a request is taken, and the address it saves;
- decoder inputs ignored during the event;
- the flags surviving a service routine through the shadow copies;
- both forms of the interrupt return.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

  typedef enum logic [2:0] {
    OP_NEXT = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_EINT = 3'd5,
    OP_DINT = 3'd6,
    OP_RSVD = 3'd7
  } seq_op_e;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_INC,
    PC_TARGET,
    PC_POPINC,
    PC_POP,
    PC_VECTOR
  } pc_sel_e;

  typedef struct packed {
    pc_sel_e pcSel;
    logic    flagLoad;
    logic    flagRestore;
    logic    flagSave;
  } seq_strobe_t;

endpackage

// File: rtl/pgm_seq_ctrl.sv
module pgm_seq_ctrl
  import pgm_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  opCode,
  input  logic [2:0]  condSel,
  input  logic        retiEn,
  input  logic        flagWe,
  input  logic        irq,
  input  logic        zeroFlag,
  input  logic        carryFlag,
  output seq_strobe_t strobe,
  output logic        secondCycle,
  output logic        intAck,
  output logic        pushEn,
  output logic        popEn,
  output logic        intEnabled
);

  logic    phase;
  logic    evtActive;
  logic    irqSample;
  logic    ieReg;
  logic    ieNext;
  logic    condOk;
  logic    takeInt;
  seq_op_e op;

  assign op = seq_op_e'(opCode);

  always_comb begin
    if (!condSel[2]) begin
      condOk = 1'b1;
    end else begin
      case (condSel[1:0])
        2'b00:   condOk = zeroFlag;
        2'b01:   condOk = !zeroFlag;
        2'b10:   condOk = carryFlag;
        default: condOk = !carryFlag;
      endcase
    end
  end

  always_comb begin
    strobe = '{pcSel: PC_HOLD, flagLoad: 1'b0, flagRestore: 1'b0, flagSave: 1'b0};
    pushEn = 1'b0;
    popEn  = 1'b0;
    ieNext = ieReg;
    if (phase) begin
      if (evtActive) begin
        strobe.pcSel    = PC_VECTOR;
        strobe.flagSave = 1'b1;
        pushEn          = 1'b1;
        ieNext          = 1'b0;
      end else begin
        strobe.flagLoad = flagWe && (op != OP_RETI);
        case (op)
          OP_JUMP: strobe.pcSel = condOk ? PC_TARGET : PC_INC;
          OP_CALL: begin
            strobe.pcSel = condOk ? PC_TARGET : PC_INC;
            pushEn       = condOk;
          end
          OP_RET: begin
            strobe.pcSel = condOk ? PC_POPINC : PC_INC;
            popEn        = condOk;
          end
          OP_RETI: begin
            strobe.pcSel       = PC_POP;
            strobe.flagRestore = 1'b1;
            popEn              = 1'b1;
            ieNext             = retiEn;
          end
          OP_EINT: begin
            strobe.pcSel = PC_INC;
            ieNext       = 1'b1;
          end
          OP_DINT: begin
            strobe.pcSel = PC_INC;
            ieNext       = 1'b0;
          end
          default: strobe.pcSel = PC_INC;
        endcase
      end
    end
  end

  assign takeInt = phase && irqSample && ieNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      evtActive <= 1'b0;
      irqSample <= 1'b0;
      ieReg     <= 1'b0;
    end else begin
      phase     <= !phase;
      irqSample <= irq;
      if (phase) begin
        ieReg     <= ieNext;
        evtActive <= takeInt;
      end
    end
  end

  assign secondCycle = phase;
  assign intAck      = phase && evtActive;
  assign intEnabled  = ieReg;

endmodule

// File: rtl/pgm_seq_dp.sv
module pgm_seq_dp
  import pgm_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       strobe,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] stackTop,
  input  logic              zeroIn,
  input  logic              carryIn,
  output logic [ADDR_W-1:0] pc,
  output logic              zeroFlag,
  output logic              carryFlag
);

  localparam logic [ADDR_W-1:0] VECTOR = '1;
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

  logic [ADDR_W-1:0] pcNext;
  logic              zeroShadow;
  logic              carryShadow;

  always_comb begin
    case (strobe.pcSel)
      PC_INC:    pcNext = pc + ONE;
      PC_TARGET: pcNext = target;
      PC_POPINC: pcNext = stackTop + ONE;
      PC_POP:    pcNext = stackTop;
      PC_VECTOR: pcNext = VECTOR;
      default:   pcNext = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      zeroFlag    <= 1'b0;
      carryFlag   <= 1'b0;
      zeroShadow  <= 1'b0;
      carryShadow <= 1'b0;
    end else begin
      pc <= pcNext;
      if (strobe.flagSave) begin
        zeroShadow  <= zeroFlag;
        carryShadow <= carryFlag;
      end
      if (strobe.flagRestore) begin
        zeroFlag  <= zeroShadow;
        carryFlag <= carryShadow;
      end else if (strobe.flagLoad) begin
        zeroFlag  <= zeroIn;
        carryFlag <= carryIn;
      end
    end
  end

endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        opCode,
  input  logic [2:0]        condSel,
  input  logic [ADDR_W-1:0] target,
  input  logic              retiEn,
  input  logic              flagWe,
  input  logic              zeroIn,
  input  logic              carryIn,
  input  logic              irq,
  input  logic [ADDR_W-1:0] stackTop,
  output logic [ADDR_W-1:0] pc,
  output logic              secondCycle,
  output logic              intAck,
  output logic              pushEn,
  output logic              popEn,
  output logic [ADDR_W-1:0] pushAddr,
  output logic              stackClear,
  output logic              zeroFlag,
  output logic              carryFlag,
  output logic              intEnabled
);

  seq_strobe_t strobe;

  pgm_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opCode     (opCode),
    .condSel    (condSel),
    .retiEn     (retiEn),
    .flagWe     (flagWe),
    .irq        (irq),
    .zeroFlag   (zeroFlag),
    .carryFlag  (carryFlag),
    .strobe     (strobe),
    .secondCycle(secondCycle),
    .intAck     (intAck),
    .pushEn     (pushEn),
    .popEn      (popEn),
    .intEnabled (intEnabled)
  );

  pgm_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .target   (target),
    .stackTop (stackTop),
    .zeroIn   (zeroIn),
    .carryIn  (carryIn),
    .pc       (pc),
    .zeroFlag (zeroFlag),
    .carryFlag(carryFlag)
  );

  assign pushAddr   = pc;
  assign stackClear = rst;

endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        opCode,
  input logic [2:0]        condSel,
  input logic [ADDR_W-1:0] stackTop,
  input logic [ADDR_W-1:0] pc,
  input logic              secondCycle,
  input logic              intAck,
  input logic              pushEn,
  input logic              popEn,
  input logic              zeroFlag,
  input logic              carryFlag,
  input logic              intEnabled
);

  localparam logic [ADDR_W-1:0] VECTOR = '1;
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

  // R1: cycles alternate, address holds over a first cycle
  a_r1_phase_toggle: assert property (@(posedge clk) disable iff (rst)
    secondCycle |=> !secondCycle);
  a_r1_phase_return: assert property (@(posedge clk) disable iff (rst)
    !secondCycle |=> secondCycle);
  a_r1_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !secondCycle |=> $stable(pc));

  // R2: plain instruction advances by one with wrap
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (secondCycle && !intAck && opCode == 3'd0) |=> (pc == $past(pc) + ONE));

  // R4: unconditional return resumes after the popped address
  a_r4_return_inc: assert property (@(posedge clk) disable iff (rst)
    (secondCycle && !intAck && opCode == 3'd3 && !condSel[2]) |=> (pc == $past(stackTop) + ONE));

  // R7: acknowledge is one cycle, then vector and enable cleared
  a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
    intAck |=> !intAck);
  a_r7_ack_second: assert property (@(posedge clk) disable iff (rst)
    intAck |-> (secondCycle && pushEn));
  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    intAck |=> (pc == VECTOR && !intEnabled));

  // R8: interrupt return always pops, resumes without increment
  a_r8_reti_pop: assert property (@(posedge clk) disable iff (rst)
    (secondCycle && !intAck && opCode == 3'd4) |-> popEn);
  a_r8_reti_addr: assert property (@(posedge clk) disable iff (rst)
    (secondCycle && !intAck && opCode == 3'd4) |=> (pc == $past(stackTop)));

  // R10: reset values
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (pc == '0 && !zeroFlag && !carryFlag && !intEnabled && !intAck && !secondCycle));

  // R11: stack strobes exclusive and only in a second cycle
  a_r11_strobes: assert property (@(posedge clk) disable iff (rst)
    (pushEn || popEn) |-> (secondCycle && !(pushEn && popEn)));

endmodule

bind pgm_seq pgm_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opCode     (opCode),
  .condSel    (condSel),
  .stackTop   (stackTop),
  .pc         (pc),
  .secondCycle(secondCycle),
  .intAck     (intAck),
  .pushEn     (pushEn),
  .popEn      (popEn),
  .zeroFlag   (zeroFlag),
  .carryFlag  (carryFlag),
  .intEnabled (intEnabled)
);

// File: tb/pgm_seq_tb.sv
module pgm_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] cond;
    logic [9:0] tgt;
    logic [9:0] top;
    logic       fwe;
    logic       z;
    logic       c;
    logic [9:0] expPc;
    logic       expPush;
    logic       expPop;
    logic       expZ;
    logic       expC;
  } vec_t;

  // op, cond, tgt, top, fwe, z, c, expPc, push, pop, Z, C
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 10'h000, 10'h000, 1'b1, 1'b1, 1'b0, 10'h001, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd1, 3'd4, 10'h120, 10'h000, 1'b0, 1'b0, 1'b0, 10'h120, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd1, 3'd5, 10'h050, 10'h000, 1'b0, 1'b0, 1'b0, 10'h121, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd0, 3'd0, 10'h000, 10'h000, 1'b1, 1'b0, 1'b1, 10'h122, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd2, 3'd6, 10'h200, 10'h000, 1'b0, 1'b0, 1'b0, 10'h200, 1'b1, 1'b0, 1'b0, 1'b1},
    '{3'd2, 3'd7, 10'h300, 10'h000, 1'b0, 1'b0, 1'b0, 10'h201, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd1, 3'd0, 10'h3FE, 10'h000, 1'b0, 1'b0, 1'b0, 10'h3FE, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd0, 3'd0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd7, 3'd0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd3, 3'd0, 10'h000, 10'h122, 1'b0, 1'b0, 1'b0, 10'h123, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd3, 3'd4, 10'h000, 10'h300, 1'b0, 1'b0, 1'b0, 10'h124, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd1, 3'd5, 10'h0AA, 10'h000, 1'b0, 1'b0, 1'b0, 10'h0AA, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd0, 3'd0, 10'h000, 10'h000, 1'b1, 1'b1, 1'b1, 10'h0AB, 1'b0, 1'b0, 1'b1, 1'b1},
    '{3'd3, 3'd6, 10'h000, 10'h3FF, 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd1, 3'd3, 10'h155, 10'h000, 1'b0, 1'b0, 1'b0, 10'h155, 1'b0, 1'b0, 1'b1, 1'b1},
    '{3'd1, 3'd0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] opCode = '0;
  logic [2:0] condSel = '0;
  logic [9:0] target = '0;
  logic       retiEn = 1'b0;
  logic       flagWe = 1'b0;
  logic       zeroIn = 1'b0;
  logic       carryIn = 1'b0;
  logic       irq = 1'b0;
  logic [9:0] stackTop = '0;
  logic [9:0] pc;
  logic       secondCycle;
  logic       intAck;
  logic       pushEn;
  logic       popEn;
  logic [9:0] pushAddr;
  logic       stackClear;
  logic       zeroFlag;
  logic       carryFlag;
  logic       intEnabled;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic       obsAck, obsPush, obsPop, ackFirst;
  logic [9:0] obsPushAddr, pcFirst, pcSecond;

  pgm_seq u_dut (
    .clk(clk), .rst(rst), .opCode(opCode), .condSel(condSel), .target(target),
    .retiEn(retiEn), .flagWe(flagWe), .zeroIn(zeroIn), .carryIn(carryIn),
    .irq(irq), .stackTop(stackTop), .pc(pc), .secondCycle(secondCycle),
    .intAck(intAck), .pushEn(pushEn), .popEn(popEn), .pushAddr(pushAddr),
    .stackClear(stackClear), .zeroFlag(zeroFlag), .carryFlag(carryFlag),
    .intEnabled(intEnabled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [2:0] cnd, input logic [9:0] tgt,
                      input logic [9:0] top, input logic re, input logic fwe,
                      input logic z, input logic c);
    ackFirst = 1'b0;
    pcFirst  = pc;
    @(negedge clk);
    while (!secondCycle) begin
      ackFirst = intAck;
      pcFirst  = pc;
      @(negedge clk);
    end
    opCode = op; condSel = cnd; target = tgt; stackTop = top;
    retiEn = re; flagWe = fwe; zeroIn = z; carryIn = c;
    #1;
    obsAck = intAck; obsPush = pushEn; obsPop = popEn;
    obsPushAddr = pushAddr; pcSecond = pc;
    @(posedge clk);
    #1;
    opCode = '0; condSel = '0; flagWe = 1'b0; retiEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] prevPc;
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 pc", pc, 0);
    check("R10 flags", {zeroFlag, carryFlag}, 0);
    check("R10 ie", intEnabled, 0);
    check("R10 stackClear", stackClear, 1);
    check("R10 ack", intAck, 0);
    check("R1 first cycle after reset", secondCycle, 0);
    rst = 1'b0;
    #1;
    check("R10 stackClear released", stackClear, 0);

    // Table walk: R2 R3 R4 R5
    prevPc = '0;
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].cond, VECS[i].tgt, VECS[i].top, 1'b0,
           VECS[i].fwe, VECS[i].z, VECS[i].c);
      check($sformatf("R3/R2 pc row %0d", i), pc, VECS[i].expPc);
      check($sformatf("R1 pc held row %0d", i), pcSecond, pcFirst);
      check($sformatf("R4 push row %0d", i), obsPush, VECS[i].expPush);
      check($sformatf("R4 pop row %0d", i), obsPop, VECS[i].expPop);
      if (VECS[i].expPush) check($sformatf("R4 pushAddr row %0d", i), obsPushAddr, prevPc);
      check($sformatf("R5 flags row %0d", i), {zeroFlag, carryFlag}, {VECS[i].expZ, VECS[i].expC});
      check($sformatf("R11 strobes row %0d", i), obsPush & obsPop, 0);
      prevPc = VECS[i].expPc;
    end

    // R6: interrupt ignored while disabled
    irq = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R6 disabled irq ack", obsAck, 0);
      check("R6 disabled irq pc", pc, 10'(k));
    end
    irq = 1'b0;
    step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 pc", pc, 10'h004);

    // R9: enable
    step(3'd5, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 enable", intEnabled, 1);
    check("R9 pc", pc, 10'h005);
    step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R5 flags set", {zeroFlag, carryFlag}, 2'b10);

    // R6/R7: request raised in first cycle of instruction at 7
    step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 pc 7", pc, 10'h007);
    irq = 1'b1;
    step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 instruction completes before event", pc, 10'h008);
    check("R6 no ack yet", obsAck, 0);
    step(3'd1, 3'd0, 10'h010, 10'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 ack in second cycle", obsAck, 1);
    check("R7 no ack in first cycle", ackFirst, 0);
    check("R7 push", obsPush, 1);
    check("R7 pushAddr preempted", obsPushAddr, 10'h008);
    check("R7 vector, inputs ignored", pc, 10'h3FF);
    check("R7 ie cleared", intEnabled, 0);
    check("R7 flags unchanged", {zeroFlag, carryFlag}, 2'b10);
    irq = 1'b0;

    // ISR body
    step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 single ack", obsAck, 0);
    check("R2 wrap in isr", pc, 10'h000);
    check("R5 isr flags", {zeroFlag, carryFlag}, 2'b01);

    // R8: return with enable
    step(3'd4, 3'd4, 10'h0, 10'h008, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 pop", obsPop, 1);
    check("R8 resume no increment", pc, 10'h008);
    check("R8 flags restored", {zeroFlag, carryFlag}, 2'b10);
    check("R8 enable", intEnabled, 1);

    // R9: disable
    step(3'd6, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 disable", intEnabled, 0);
    check("R9 pc", pc, 10'h009);
    step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 clear flags", {zeroFlag, carryFlag}, 2'b00);

    // R8: return with disable form
    step(3'd4, 3'd0, 10'h0, 10'h055, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R8 disable form pc", pc, 10'h055);
    check("R8 disable form ie", intEnabled, 0);
    check("R8 shadow restored, ALU ignored", {zeroFlag, carryFlag}, 2'b10);

    // R10: reset beats a pending interrupt
    step(3'd5, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 enable again", intEnabled, 1);
    irq = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R10 priority pc", pc, 0);
    check("R10 priority ie", intEnabled, 0);
    check("R10 priority ack", intAck, 0);
    check("R10 priority flags", {zeroFlag, carryFlag}, 0);
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
    step(3'd0, 3'd0, 10'h0, 10'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 after reset ignored", obsAck, 0);
    check("R2 after reset", pc, 10'h001);
    irq = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule